// File: doc/BRIEF.md
# Status-Decoding Bus Command Generator

This block sits beside a processor that has no bus strobes of its own. The processor reports only a 3-bit bus status code. The block watches that code and recognises the start of a bus cycle when the code moves from the idle value (111) to an active value. It then steps through the four bus phases T1, T2, T3 and T4 by itself, and inserts wait phases after T3 for as long as READY stays low.

From the phase and the cycle type captured at the start, the block drives these outputs:

- Address latch pulse and transceiver controls: `ale`, `den`, `dt_r`.
- Active-low read commands: memory read, I/O read and interrupt acknowledge.
- Active-low write commands in two forms. The advanced write opens one phase ahead of the normal write.

All commands return high when T4 ends.

Top module: `bus_cmd_gen`

## Requirements
- R1: While `rst_n` is low, every active-low command output is 1, `ale` and `den` are 0 and `dt_r` is 1.
- R2: A bus cycle starts only when the status sampled at a clock edge is active while the status sampled at the previous edge was 111. A status that stays active, or that moves from one active code to another, starts nothing. `ale` is 1 for exactly the T1 phase of each cycle.
- R3: Status 111 (idle) and status 011 (halt) start no cycle. They produce no `ale`, no `den` and no command.
- R4: Codes 000, 001, 100 and 101 are receive cycles. For these, `dt_r` is 0 from T1 through T4. At every other time `dt_r` is 1.
- R5: `den` is 1 from T2 through T4 of every cycle, including any wait phases, and 0 otherwise.
- R6: The read command is active (0) from T2 through T4. The command is chosen by the status code:
  - 000 selects `inta_n`.
  - 001 selects `iord_n`.
  - 100 (code fetch) and 101 select `mrd_n`.
- R7: Code 010 drives `aiowr_n` low and code 110 drives `amwr_n` low, from T2 through T4.
- R8: Code 010 drives `iowr_n` low and code 110 drives `mwr_n` low, only from T3 through T4.
- R9: `ready` is sampled at the edge that ends T3 and at the edge that ends each wait phase. A 0 adds one wait phase, and all outputs hold their T3 values during it.
- R10: At most two command outputs are low at any time, and all of them are high once T4 ends.
- R11: A passive-to-active status edge seen at the edge that ends T4 begins T1 of the next cycle directly, with no idle phase in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| status | input | 3 | Bus status code from the processor |
| ready | input | 1 | Transfer-complete input, active high |
| ale | output | 1 | Address latch pulse during T1 |
| den | output | 1 | Data transceiver enable |
| dt_r | output | 1 | Transceiver direction: 1 for transmit, 0 for receive |
| mrd_n | output | 1 | Memory read command |
| mwr_n | output | 1 | Memory write command |
| amwr_n | output | 1 | Advanced memory write command |
| iord_n | output | 1 | I/O read command |
| iowr_n | output | 1 | I/O write command |
| aiowr_n | output | 1 | Advanced I/O write command |
| inta_n | output | 1 | Interrupt acknowledge command |

## Verification
The bench sweeps all eight status codes with zero, one and three wait phases, and compares every output in every phase with a table of phases computed in the bench. Each corner case below has a specific failure it would expose:

- **Status held active, or moved between two active codes without passing through idle.** A design that starts cycles on level instead of on edge would pulse `ale` again here.
- **Halt code.** A design that starts a cycle on any code other than idle would issue a cycle here.
- **Wait phases.** A design that samples `ready` in the wrong phase would lose or add a wait phase, and its `den` and command lengths would be off by one.
- **New start inside T4.** A design without the direct T4-to-T1 path would drop the second cycle entirely.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  localparam int SW = 3;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_t;

  localparam logic [SW-1:0] ST_IDLE  = 3'b111;
  localparam logic [SW-1:0] ST_HALT  = 3'b011;
  localparam logic [SW-1:0] ST_INTA  = 3'b000;
  localparam logic [SW-1:0] ST_IORD  = 3'b001;
  localparam logic [SW-1:0] ST_IOWR  = 3'b010;
  localparam logic [SW-1:0] ST_FETCH = 3'b100;
  localparam logic [SW-1:0] ST_MRD   = 3'b101;
  localparam logic [SW-1:0] ST_MWR   = 3'b110;

  function automatic logic is_rx(input logic [SW-1:0] c);
    return (c == ST_INTA) || (c == ST_IORD) || (c == ST_FETCH) || (c == ST_MRD);
  endfunction

  function automatic logic is_tx(input logic [SW-1:0] c);
    return (c == ST_IOWR) || (c == ST_MWR);
  endfunction

  function automatic logic starts_cycle(input logic [SW-1:0] prev,
                                        input logic [SW-1:0] cur);
    return (prev == ST_IDLE) && (cur != ST_IDLE) && (cur != ST_HALT);
  endfunction

  function automatic logic data_window(input phase_t p);
    return (p == PH_T2) || (p == PH_T3) || (p == PH_TW) || (p == PH_T4);
  endfunction

  function automatic logic late_window(input phase_t p);
    return (p == PH_T3) || (p == PH_TW) || (p == PH_T4);
  endfunction

endpackage

// File: rtl/bcg_edge.sv
module bcg_edge
  import bcg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] status,
  output logic [SW-1:0] prev,
  output logic          start
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= ST_IDLE;
    else        prev <= status;
  end

  assign start = starts_cycle(prev, status);
endmodule

// File: rtl/bcg_seq.sv
module bcg_seq
  import bcg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] status,
  input  logic          ready,
  output phase_t        phase,
  output logic [SW-1:0] code
);
  phase_t nxt;
  logic   take;

  assign take = start && ((phase == PH_IDLE) || (phase == PH_T4));

  always_comb begin
    nxt = phase;
    case (phase)
      PH_IDLE:     nxt = take ? PH_T1 : PH_IDLE;
      PH_T1:       nxt = PH_T2;
      PH_T2:       nxt = PH_T3;
      PH_T3, PH_TW: nxt = ready ? PH_T4 : PH_TW;
      PH_T4:       nxt = take ? PH_T1 : PH_IDLE;
      default:     nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      code  <= ST_IDLE;
    end else begin
      phase <= nxt;
      if (take) code <= status;
    end
  end
endmodule

// File: rtl/bcg_dec.sv
module bcg_dec
  import bcg_pkg::*;
(
  input  phase_t        phase,
  input  logic [SW-1:0] code,
  output logic          ale,
  output logic          den,
  output logic          dt_r,
  output logic          mrd_n,
  output logic          mwr_n,
  output logic          amwr_n,
  output logic          iord_n,
  output logic          iowr_n,
  output logic          aiowr_n,
  output logic          inta_n
);
  logic rd_on, aw_on, nw_on, busy;

  always_comb begin
    busy  = (phase != PH_IDLE);
    rd_on = data_window(phase) && is_rx(code);
    aw_on = data_window(phase) && is_tx(code);
    nw_on = late_window(phase) && is_tx(code);

    ale     = (phase == PH_T1);
    den     = data_window(phase);
    dt_r    = !(busy && is_rx(code));
    mrd_n   = !(rd_on && code[2]);
    iord_n  = !(rd_on && (code == ST_IORD));
    inta_n  = !(rd_on && (code == ST_INTA));
    amwr_n  = !(aw_on && code[2]);
    aiowr_n = !(aw_on && !code[2]);
    mwr_n   = !(nw_on && code[2]);
    iowr_n  = !(nw_on && !code[2]);
  end
endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
  import bcg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] status,
  input  logic       ready,
  output logic       ale,
  output logic       den,
  output logic       dt_r,
  output logic       mrd_n,
  output logic       mwr_n,
  output logic       amwr_n,
  output logic       iord_n,
  output logic       iowr_n,
  output logic       aiowr_n,
  output logic       inta_n
);
  logic [SW-1:0] prev_w;
  logic          start_w;
  phase_t        phase_e;
  logic [2:0]    phase_w;
  logic [SW-1:0] code_w;

  bcg_edge u_edge (
    .clk(clk), .rst_n(rst_n), .status(status),
    .prev(prev_w), .start(start_w)
  );

  bcg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_w), .status(status),
    .ready(ready), .phase(phase_e), .code(code_w)
  );

  assign phase_w = phase_e;

  bcg_dec u_dec (
    .phase(phase_e), .code(code_w),
    .ale(ale), .den(den), .dt_r(dt_r),
    .mrd_n(mrd_n), .mwr_n(mwr_n), .amwr_n(amwr_n),
    .iord_n(iord_n), .iowr_n(iowr_n), .aiowr_n(aiowr_n), .inta_n(inta_n)
  );
endmodule

// File: rtl/bcg_chk.sv
module bcg_chk
  import bcg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] status,
  input logic       ready,
  input logic [2:0] prev,
  input logic       start,
  input logic [2:0] phase,
  input logic       ale,
  input logic       den,
  input logic       mrd_n,
  input logic       mwr_n,
  input logic       amwr_n,
  input logic       iord_n,
  input logic       iowr_n,
  input logic       aiowr_n,
  input logic       inta_n
);
  logic [6:0] cmd_low;
  logic       rd_low, wr_low;
  assign cmd_low = ~{mrd_n, mwr_n, amwr_n, iord_n, iowr_n, aiowr_n, inta_n};
  assign rd_low  = !mrd_n || !iord_n || !inta_n;
  assign wr_low  = !mwr_n || !amwr_n || !iowr_n || !aiowr_n;

  AST_ALE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R2
  AST_ALE_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> $past(start)); // R2
  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && prev == ST_IDLE && status == ST_HALT) |=> !ale); // R3
  AST_READ_NEEDS_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_low |-> den); // R6
  AST_NORMAL_AFTER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mwr_n) || $fell(iowr_n)) |-> $past(!amwr_n || !aiowr_n)); // R8
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_T3 || phase == PH_TW) && !ready) |=> (phase == PH_TW && den)); // R9
  AST_MAX_TWO_CMDS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cmd_low) <= 2); // R10
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_low && wr_low)); // R10
endmodule

bind bus_cmd_gen bcg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .ready(ready),
  .prev(prev_w), .start(start_w), .phase(phase_w),
  .ale(ale), .den(den), .mrd_n(mrd_n), .mwr_n(mwr_n), .amwr_n(amwr_n),
  .iord_n(iord_n), .iowr_n(iowr_n), .aiowr_n(aiowr_n), .inta_n(inta_n)
);

// File: tb/bus_cmd_gen_test.sv
`timescale 1ns/1ps
module bus_cmd_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] status = 3'b111;
  logic ready = 1'b1;
  logic ale, den, dt_r, mrd_n, mwr_n, amwr_n, iord_n, iowr_n, aiowr_n, inta_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_cmd_gen uut (
    .clk(clk), .rst_n(rst_n), .status(status), .ready(ready),
    .ale(ale), .den(den), .dt_r(dt_r), .mrd_n(mrd_n), .mwr_n(mwr_n),
    .amwr_n(amwr_n), .iord_n(iord_n), .iowr_n(iowr_n), .aiowr_n(aiowr_n),
    .inta_n(inta_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // ph: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4
  task automatic compare(input logic [2:0] c, input int ph, input string ctx);
    bit rx, tx, dat, late;
    int lows;
    rx   = (ph != 0) && (c == 3'd0 || c == 3'd1 || c == 3'd4 || c == 3'd5);
    tx   = (ph != 0) && (c == 3'd2 || c == 3'd6);
    dat  = (ph >= 2);
    late = (ph >= 3);
    chk({"R2 ale ", ctx}, ale, ph == 1);
    chk({(ph == 4) ? "R9 den " : "R5 den ", ctx}, den, dat);
    chk({"R4 dt_r ", ctx}, dt_r, !rx);
    chk({"R6 mrd_n ", ctx}, mrd_n, !(rx && dat && c[2]));
    chk({"R6 iord_n ", ctx}, iord_n, !(rx && dat && c == 3'd1));
    chk({"R6 inta_n ", ctx}, inta_n, !(rx && dat && c == 3'd0));
    chk({"R7 amwr_n ", ctx}, amwr_n, !(tx && dat && c[2]));
    chk({"R7 aiowr_n ", ctx}, aiowr_n, !(tx && dat && !c[2]));
    chk({"R8 mwr_n ", ctx}, mwr_n, !(tx && late && c[2]));
    chk({"R8 iowr_n ", ctx}, iowr_n, !(tx && late && !c[2]));
    lows = 7 - $countones({mrd_n, mwr_n, amwr_n, iord_n, iowr_n, aiowr_n, inta_n});
    chk({"R10 count ", ctx}, lows <= 2, 1'b1);
  endtask

  // Called at a negedge. nxt == 7 means return to idle afterwards.
  task automatic run_cycle(input logic [2:0] c, input int waits,
                           input bit preset, input bit hold, input logic [2:0] nxt,
                           input string ctx);
    if (!preset) status = c;
    ready = 1'b1;
    @(negedge clk); compare(c, 1, ctx);
    @(negedge clk); compare(c, 2, ctx);
    if (!hold) status = 3'b111;
    @(negedge clk); compare(c, 3, ctx);
    ready = (waits == 0);
    for (int w = 0; w < waits; w++) begin
      @(negedge clk); compare(c, 4, ctx);
      ready = (w == waits - 1);
    end
    @(negedge clk); compare(c, 5, ctx);
    ready = 1'b1;
    if (!hold) status = nxt;
    if (nxt == 3'b111) begin
      @(negedge clk); compare(c, 0, {ctx, " R10 after T4"});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare(3'd7, 0, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk); compare(3'd7, 0, "R1 after reset");

    for (int c = 0; c < 8; c++) begin
      if (c == 7 || c == 3) begin
        status = c[2:0];
        for (int k = 0; k < 4; k++) begin
          @(negedge clk); compare(3'd7, 0, "R3 no cycle");
        end
        status = 3'b111;
        @(negedge clk);
      end else begin
        for (int wi = 0; wi < 3; wi++) begin
          run_cycle(c[2:0], (wi == 2) ? 3 : wi, 1'b0, 1'b0, 3'b111, "sweep R9");
        end
      end
    end

    // R2: held active status and active-to-active change start nothing new
    run_cycle(3'd5, 0, 1'b0, 1'b1, 3'b111, "R2 held");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); compare(3'd7, 0, "R2 held idle");
    end
    status = 3'b110;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); compare(3'd7, 0, "R2 active change");
    end
    status = 3'b111;
    @(negedge clk);

    // R11: back-to-back cycles, new edge seen at end of T4
    run_cycle(3'd6, 1, 1'b0, 1'b0, 3'd1, "R11 first");
    run_cycle(3'd1, 0, 1'b1, 1'b0, 3'd2, "R11 second");
    run_cycle(3'd2, 2, 1'b1, 1'b0, 3'b111, "R11 third");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule